// File: doc/BRIEF.md
# Reset and Clock Start-up Sequencer

This block keeps the processor core in reset after power-on, brown-out or an external pin reset. It releases the core only once the system clock can be used. A fixed power-on delay always runs first. An optional power-up delay follows, timed on the always-on slow clock. The clock source is then qualified according to the selected oscillator type. Crystal modes must see a fixed number of oscillator edges. The crystal-with-PLL mode must also see the PLL report lock. Internal RC and external clock sources are treated as ready at once.

The oscillator mode, the power-up length and the clock-monitor enable are configuration inputs. They are captured only while the power-on delay stage runs, so every restart picks them up again. When both the power-up delay and the clock monitor are turned off, the core reset drops as soon as the power-on delay ends. The clock gate then stays closed until the clock qualifies, so the core sits frozen at its reset vector. Three sticky cause bits record which kind of reset happened, and software clears them with write-one-to-clear strobes.

Top module: `rstseq_top`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1, `clk_en_o` is 0 and `cause_o` is 3'b001 (bit0 power-on, bit1 brown-out, bit2 pin).
- R2: After any reset event ends, the power-on delay stage lasts exactly POR_CYC cycles of `clk_i`.
- R3: A nonzero power-up length P adds exactly P cycles after the power-on delay, and a length of 0 skips that stage.
- R4: In crystal modes (`osc_mode_i` 2'b10 crystal, 2'b11 crystal with PLL), the clock stays held until OST_EDGES cycles with `osc_tick_i` high have been seen. Modes 2'b00 (internal RC) and 2'b01 (external clock) skip this wait.
- R5: In mode 2'b11, after the edge count the sequencer waits for `pll_lock_i`, and `clk_en_o` rises in the cycle after lock is sampled.
- R6: `clk_en_o` is high only when the sequence is complete, and it stays high until the next reset event, whatever the PLL lock or tick inputs do.
- R7: With a power-up length of 0 and `fscm_en_i` at 0, `core_rst_o` falls right after the power-on delay while `clk_en_o` stays 0 until the clock qualifies.
- R8: In every other configuration, `core_rst_o` falls in the same cycle that `clk_en_o` rises.
- R9: A `bor_i` pulse restarts the whole sequence from the power-on delay and sets cause bit1. The configuration is taken fresh during that delay, and configuration changes made at other times have no effect.
- R10: While `pin_rst_n_i` is low, the core is held in reset with the clock gated and cause bit2 is set. The sequence restarts when the pin returns high.
- R11: Cause bits are sticky. A 1 on a bit of `cause_clr_i` clears that bit on the next clock, unless the same cause is being set in that cycle, because setting wins.
- R12: Oscillator ticks seen before the edge-count stage begins do not count toward it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on slow clock |
| por_i | input | 1 | Power-on reset, asynchronous, active high |
| bor_i | input | 1 | Brown-out reset pulse, synchronous |
| pin_rst_n_i | input | 1 | External reset pin, active low |
| osc_mode_i | input | 2 | Oscillator type: 0 internal RC, 1 external clock, 2 crystal, 3 crystal with PLL |
| pwrt_len_i | input | PWRT_W | Power-up delay in clock cycles, 0 skips |
| fscm_en_i | input | 1 | Clock monitor enabled |
| osc_tick_i | input | 1 | One oscillator edge seen in this cycle |
| pll_lock_i | input | 1 | PLL lock indication |
| cause_clr_i | input | 3 | Write-one-to-clear strobes for the cause bits |
| core_rst_o | output | 1 | Core reset, active high |
| clk_en_o | output | 1 | System clock gate enable |
| cause_o | output | 3 | Sticky reset cause bits |

## Verification
The sequence is run once for each of the four oscillator modes. Power-up length and clock-monitor settings are chosen so that the slow path (reset held until the clock qualifies) can be told apart from the fast path (reset released early, clock gated). Release latencies are measured against POR_CYC + P + OST_EDGES (+1 with PLL). This separates a skipped stage from a counted one, and it shows when ticks leak in before the edge-count stage. Configuration is changed while running and then a brown-out is raised, which shows whether the settings are captured only during the power-on delay. A cycle-by-cycle reference model checks every output on every clock, including the cause bits under clears that collide with new events.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_PORDLY = 3'd0,
    ST_PWRT   = 3'd1,
    ST_OST    = 3'd2,
    ST_PLL    = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    OSC_INTRC    = 2'd0,
    OSC_EXTCLK   = 2'd1,
    OSC_XTAL     = 2'd2,
    OSC_XTAL_PLL = 2'd3
  } osc_mode_e;

  localparam int unsigned CAUSE_W   = 3;
  localparam int unsigned CAUSE_POR = 0;
  localparam int unsigned CAUSE_BOR = 1;
  localparam int unsigned CAUSE_PIN = 2;

  function automatic logic needs_ost(osc_mode_e m);
    return (m == OSC_XTAL) || (m == OSC_XTAL_PLL);
  endfunction

  function automatic logic needs_pll(osc_mode_e m);
    return m == OSC_XTAL_PLL;
  endfunction

  function automatic seq_state_e clock_stage(osc_mode_e m);
    return needs_ost(m) ? ST_OST : ST_RUN;
  endfunction

  // True on the final cycle of a stage that lasts 'limit' counts.
  function automatic logic last_count(int unsigned count, int unsigned limit);
    return (count + 1) == limit;
  endfunction

  function automatic logic fast_exit(logic pwrt_zero, logic fscm_en);
    return pwrt_zero && !fscm_en;
  endfunction

endpackage

// File: rtl/rstseq_cause.sv
module rstseq_cause
  import rstseq_pkg::*;
(
  input  logic               clk_i,
  input  logic               por_i,
  input  logic               bor_i,
  input  logic               pin_rst_n_i,
  input  logic [CAUSE_W-1:0] clr_i,
  output logic [CAUSE_W-1:0] cause_o
);

  logic [CAUSE_W-1:0] set_vec;

  always_comb begin
    set_vec            = '0;
    set_vec[CAUSE_BOR] = bor_i;
    set_vec[CAUSE_PIN] = !pin_rst_n_i;
  end

  for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
    localparam logic RST_VAL = (i == CAUSE_POR);
    logic flag_q;

    always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) flag_q <= RST_VAL;
      else       flag_q <= (flag_q && !clr_i[i]) || set_vec[i];
    end

    assign cause_o[i] = flag_q;

    AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (por_i)
      (flag_q && !clr_i[i]) |=> flag_q); // R11
    AST_CAUSE_SET_WINS: assert property (@(posedge clk_i) disable iff (por_i)
      set_vec[i] |=> flag_q); // R11
  end

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int unsigned POR_CYC   = 8,
  parameter int unsigned OST_EDGES = 1024,
  parameter int unsigned PWRT_W    = 8
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              restart_i,
  input  logic [1:0]        osc_mode_i,
  input  logic [PWRT_W-1:0] pwrt_len_i,
  input  logic              fscm_en_i,
  input  logic              osc_tick_i,
  input  logic              pll_lock_i,
  output logic              core_rst_o,
  output logic              clk_en_o
);

  localparam int unsigned W_POR = $clog2(POR_CYC + 1);
  localparam int unsigned W_OST = $clog2(OST_EDGES + 1);
  localparam int unsigned W_MAX = (W_POR > W_OST) ? W_POR : W_OST;
  localparam int unsigned CNT_W = (W_MAX > PWRT_W) ? W_MAX : PWRT_W;

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  osc_mode_e         mode_q;
  logic [PWRT_W-1:0] pwrt_q;
  logic              fscm_q;

  // Named stage events, used by the assertions below.
  osc_mode_e  mode_in;
  seq_state_e after_por;
  logic       in_por, por_done, pwrt_done, ost_done, pll_done;

  assign mode_in   = osc_mode_e'(osc_mode_i);
  assign after_por = (pwrt_len_i != '0) ? ST_PWRT : clock_stage(mode_in);
  assign in_por    = (st_q == ST_PORDLY);
  assign por_done  = in_por && last_count(32'(cnt_q), POR_CYC);
  assign pwrt_done = (st_q == ST_PWRT) && last_count(32'(cnt_q), 32'(pwrt_q));
  assign ost_done  = (st_q == ST_OST) && osc_tick_i && last_count(32'(cnt_q), OST_EDGES);
  assign pll_done  = (st_q == ST_PLL) && pll_lock_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (restart_i) begin
      st_d  = ST_PORDLY;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_PORDLY: begin
          if (por_done) begin st_d = after_por; cnt_d = '0; end
          else cnt_d = cnt_q + 1'b1;
        end
        ST_PWRT: begin
          if (pwrt_done) begin st_d = clock_stage(mode_q); cnt_d = '0; end
          else cnt_d = cnt_q + 1'b1;
        end
        ST_OST: begin
          if (ost_done) begin
            st_d  = needs_pll(mode_q) ? ST_PLL : ST_RUN;
            cnt_d = '0;
          end else if (osc_tick_i) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PLL:  if (pll_done) st_d = ST_RUN;
        ST_RUN:  st_d = ST_RUN;
        default: begin st_d = ST_PORDLY; cnt_d = '0; end
      endcase
    end
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      st_q   <= ST_PORDLY;
      cnt_q  <= '0;
      mode_q <= OSC_INTRC;
      pwrt_q <= '0;
      fscm_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (in_por) begin
        mode_q <= mode_in;
        pwrt_q <= pwrt_len_i;
        fscm_q <= fscm_en_i;
      end
    end
  end

  assign clk_en_o   = (st_q == ST_RUN);
  assign core_rst_o = fast_exit(pwrt_q == '0, fscm_q) ? in_por : !clk_en_o;

  AST_OST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (por_i)
    (st_q == ST_OST) |-> (32'(cnt_q) < OST_EDGES)); // R4
  AST_PLL_HOLD: assert property (@(posedge clk_i) disable iff (por_i)
    (st_q == ST_PLL && !pll_lock_i && !restart_i) |=> (st_q == ST_PLL)); // R5
  AST_RESTART_TO_POR: assert property (@(posedge clk_i) disable iff (por_i)
    restart_i |=> (in_por && cnt_q == '0)); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (por_i)
    !in_por |=> ($stable(mode_q) && $stable(pwrt_q) && $stable(fscm_q))); // R9
  AST_NO_EARLY_TICKS: assert property (@(posedge clk_i) disable iff (por_i)
    (st_q != ST_OST && st_d == ST_OST) |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int unsigned POR_CYC   = 8,
  parameter int unsigned OST_EDGES = 1024,
  parameter int unsigned PWRT_W    = 8
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              pin_rst_n_i,
  input  logic [1:0]        osc_mode_i,
  input  logic [PWRT_W-1:0] pwrt_len_i,
  input  logic              fscm_en_i,
  input  logic              osc_tick_i,
  input  logic              pll_lock_i,
  input  logic [2:0]        cause_clr_i,
  output logic              core_rst_o,
  output logic              clk_en_o,
  output logic [2:0]        cause_o
);

  logic restart;
  assign restart = bor_i || !pin_rst_n_i;

  rstseq_ctrl #(
    .POR_CYC   (POR_CYC),
    .OST_EDGES (OST_EDGES),
    .PWRT_W    (PWRT_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .restart_i  (restart),
    .osc_mode_i (osc_mode_i),
    .pwrt_len_i (pwrt_len_i),
    .fscm_en_i  (fscm_en_i),
    .osc_tick_i (osc_tick_i),
    .pll_lock_i (pll_lock_i),
    .core_rst_o (core_rst_o),
    .clk_en_o   (clk_en_o)
  );

  rstseq_cause u_cause (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .bor_i       (bor_i),
    .pin_rst_n_i (pin_rst_n_i),
    .clr_i       (cause_clr_i),
    .cause_o     (cause_o)
  );

  AST_CLK_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (por_i)
    clk_en_o |-> !core_rst_o); // R8
  AST_RUN_HOLDS: assert property (@(posedge clk_i) disable iff (por_i)
    (clk_en_o && !restart) |=> clk_en_o); // R6
  AST_EVENT_HOLDS_CORE: assert property (@(posedge clk_i) disable iff (por_i)
    restart |=> (core_rst_o && !clk_en_o)); // R10

endmodule

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb_top;

  localparam int POR_CYC   = 8;
  localparam int OST_EDGES = 1024;
  localparam int PWRT_W    = 8;

  logic              clk = 1'b0;
  logic              por = 1'b1;
  logic              bor = 1'b0;
  logic              pin_n = 1'b1;
  logic [1:0]        mode = 2'd0;
  logic [PWRT_W-1:0] pwrt = '0;
  logic              fscm = 1'b1;
  logic              tick = 1'b0;
  logic              lock = 1'b0;
  logic [2:0]        clr = 3'b000;
  logic              core_rst, clk_en;
  logic [2:0]        cause;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rstseq_top #(.POR_CYC(POR_CYC), .OST_EDGES(OST_EDGES), .PWRT_W(PWRT_W)) dut_i (
    .clk_i(clk), .por_i(por), .bor_i(bor), .pin_rst_n_i(pin_n),
    .osc_mode_i(mode), .pwrt_len_i(pwrt), .fscm_en_i(fscm),
    .osc_tick_i(tick), .pll_lock_i(lock), .cause_clr_i(clr),
    .core_rst_o(core_rst), .clk_en_o(clk_en), .cause_o(cause)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 power-on delay, 1 power-up, 2 edge count, 3 lock wait, 4 running.
  int       m_phase, m_left, m_mode, m_pwrt;
  bit       m_fscm;
  bit [2:0] m_cause;

  task automatic enter_clock_phase();
    if (m_mode >= 2) begin m_phase = 2; m_left = OST_EDGES; end
    else m_phase = 4;
  endtask

  always @(posedge clk or posedge por) begin
    if (por) begin
      m_phase = 0; m_left = POR_CYC; m_mode = 0; m_pwrt = 0; m_fscm = 0;
      m_cause = 3'b001;
    end else begin
      m_cause = (m_cause & ~clr) | {!pin_n, bor, 1'b0};
      if (m_phase == 0) begin m_mode = int'(mode); m_pwrt = int'(pwrt); m_fscm = fscm; end
      if (bor || !pin_n) begin
        m_phase = 0; m_left = POR_CYC;
      end else begin
        case (m_phase)
          0: begin
            m_left--;
            if (m_left == 0) begin
              if (m_pwrt > 0) begin m_phase = 1; m_left = m_pwrt; end
              else enter_clock_phase();
            end
          end
          1: begin m_left--; if (m_left == 0) enter_clock_phase(); end
          2: if (tick) begin
               m_left--;
               if (m_left == 0) m_phase = (m_mode == 3) ? 3 : 4;
             end
          3: if (lock) m_phase = 4;
          default: ;
        endcase
      end
    end
  end

  function automatic string phase_tag(int p);
    case (p)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!por && !done) begin
      bit exp_en, exp_rst;
      exp_en  = (m_phase == 4);
      exp_rst = (m_pwrt == 0 && !m_fscm) ? (m_phase == 0) : !exp_en;
      check(clk_en === exp_en, {phase_tag(m_phase), " clk_en"}, int'(clk_en), int'(exp_en));
      check(core_rst === exp_rst, (m_pwrt == 0 && !m_fscm) ? "R7 core_rst" : "R8 core_rst",
            int'(core_rst), int'(exp_rst));
      check(cause === m_cause, "R11 cause", int'(cause), int'(m_cause));
    end
  end

  task automatic count_to_clk(output int n);
    n = 0;
    while (clk_en !== 1'b1 && n < 6000) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_bor();
    @(negedge clk); bor = 1'b1;
    @(negedge clk); bor = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    // R1: power-on reset state
    repeat (3) @(negedge clk);
    check(core_rst === 1'b1, "R1 core_rst", int'(core_rst), 1);
    check(clk_en === 1'b0, "R1 clk_en", int'(clk_en), 0);
    check(cause === 3'b001, "R1 cause", int'(cause), 1);
    por = 1'b0;
    // R2: internal RC, no power-up delay, monitor on
    count_to_clk(n);
    check(n == POR_CYC, "R2 release latency", n, POR_CYC);

    // R10: pin reset, external clock, power-up 5, monitor off
    @(negedge clk); mode = 2'd1; pwrt = 8'd5; fscm = 1'b0; pin_n = 1'b0;
    repeat (3) @(negedge clk);
    check(core_rst === 1'b1 && clk_en === 1'b0, "R10 held", int'({core_rst, clk_en}), 2);
    check(cause[2] === 1'b1, "R10 cause pin", int'(cause[2]), 1);
    pin_n = 1'b1;
    count_to_clk(n);
    check(n == POR_CYC + 5, "R3 power-up length", n, POR_CYC + 5);

    // R11: clear all cause bits
    @(negedge clk); clr = 3'b111;
    @(negedge clk); clr = 3'b000;
    check(cause === 3'b000, "R11 cleared", int'(cause), 0);
    // R11: clear and brown-out in the same cycle, set wins
    @(negedge clk); clr = 3'b010; bor = 1'b1;
    @(negedge clk); clr = 3'b000; bor = 1'b0;
    check(cause === 3'b010, "R11 set wins", int'(cause), 2);
    count_to_clk(n);

    // R7 and R4: crystal, fast path, ticks every cycle
    @(negedge clk); mode = 2'd2; pwrt = 8'd0; fscm = 1'b0; tick = 1'b1; clr = 3'b111;
    @(negedge clk); clr = 3'b000;
    pulse_bor();
    check(cause === 3'b010, "R9 cause bor", int'(cause), 2);
    repeat (POR_CYC) @(negedge clk);
    check(core_rst === 1'b0 && clk_en === 1'b0, "R7 frozen at vector",
          int'({core_rst, clk_en}), 0);
    count_to_clk(n);
    check(n == OST_EDGES, "R4 edge count", n + POR_CYC, POR_CYC + OST_EDGES);

    // R12: ticks during power-on and power-up stages are not counted
    @(negedge clk); pwrt = 8'd3; fscm = 1'b1;
    pulse_bor();
    repeat (POR_CYC + 3 + OST_EDGES - 1) @(negedge clk);
    check(clk_en === 1'b0 && core_rst === 1'b1, "R12 no early ticks",
          int'({core_rst, clk_en}), 2);
    @(negedge clk);
    check(clk_en === 1'b1, "R4 released on last edge", int'(clk_en), 1);

    // R5: crystal with PLL, lock late
    @(negedge clk); mode = 2'd3; pwrt = 8'd0; fscm = 1'b1; lock = 1'b0;
    pulse_bor();
    repeat (POR_CYC + OST_EDGES + 20) @(negedge clk);
    check(clk_en === 1'b0 && core_rst === 1'b1, "R5 waits for lock",
          int'({core_rst, clk_en}), 2);
    lock = 1'b1;
    @(negedge clk);
    check(clk_en === 1'b1 && core_rst === 1'b0, "R5 lock releases",
          int'({core_rst, clk_en}), 1);
    // R6: losing lock or ticks while running has no effect
    lock = 1'b0; tick = 1'b0;
    repeat (10) @(negedge clk);
    check(clk_en === 1'b1, "R6 run holds", int'(clk_en), 1);

    // R9: configuration changes while running are ignored, a brown-out picks them up
    mode = 2'd0; pwrt = 8'd40;
    repeat (5) @(negedge clk);
    check(clk_en === 1'b1 && core_rst === 1'b0, "R9 config ignored in run",
          int'({core_rst, clk_en}), 1);
    pwrt = 8'd0;
    pulse_bor();
    count_to_clk(n);
    check(n == POR_CYC, "R9 new config latched", n, POR_CYC);

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule